// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block decides which of up to fifteen requesting clients may use a memory port on each transfer. Time is divided into slots. A programmable table names the client that owns each slot. Each address region has its own table and its own arbitration lane, and the two lanes work independently. A per-region slot pointer walks its table. When the slot's owner is requesting in that region, the owner receives the grant. When the owner is not requesting, the slot goes to the lowest-numbered client that is requesting in that region. This reserves bandwidth for clients named in many table entries. Slots left unused by their owner still do useful work.

A grant covers one burst. The burst ends after the client's programmed beat limit, or earlier if the client stops requesting. The region pointer then moves on by one slot. A lane with no requesters moves its pointer by one slot every cycle. Software loads the table entries and the per-client burst limits through a simple write port, one entry per write. The block's real job is the slot schedule that software computes.

Top module: `tdm_slot_arb`

## Requirements
- R1: After reset no client is granted. Slot i of every region table holds client (i mod 15). Every client's burst limit field is 3, which allows 4 beats. Both slot pointers are at slot 0.
- R2: A client's grant is asserted in the cycle after a cycle in which it requested. A lane that sees requests while idle grants exactly one client starting in the next cycle.
- R3: When the client named by the current slot entry is not requesting in that region, the lowest-indexed requester in that region is granted. An entry value of 15 names no client.
- R4: Each region grants at most one client at a time. After every burst, the lane spends one cycle with no grant before it grants again.
- R5: A lane with no requesters in its region advances its slot pointer by one every cycle. The pointer wraps from slot 63 to slot 0.
- R6: The pointer of a region advances by exactly one slot when a burst in that region ends.
- R7: A configuration write with kind 0 stores cfg_data_i[3:0] as the client index of entry cfg_idx_i in the table of region cfg_rgn_i. The new entry takes effect from the next cycle.
- R8: A burst-limit field value k allows at most k+1 granted beats per burst. A configuration write with kind 1 stores cfg_data_i[3:0] as the limit of client cfg_idx_i. A kind-1 write with cfg_idx_i of 15 or more changes no limit.
- R9: A client takes part only in the lane selected by its region bit (req_rgn_i[c], 0 or 1). The two lanes arbitrate and advance independently and may grant different clients in the same cycle.
- R10: When a granted client drops its request, its grant is gone in the next cycle and the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 15 | Per-client request |
| req_rgn_i | input | 15 | Per-client region-select address bit |
| gnt_o | output | 15 | Per-client grant |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 1 | 0 writes a slot entry, 1 writes a burst limit |
| cfg_rgn_i | input | 1 | Target region for slot-entry writes |
| cfg_idx_i | input | 6 | Slot index or client index |
| cfg_data_i | input | 4 | Client index or burst limit value |

## Verification
The hardest condition to reach from the ports is a known pointer position, because the pointer moves on every idle cycle as well as at the end of every burst. To reach the wrap from slot 63 and a chosen slot owner, the stimulus starts from a fresh reset and holds the lane idle for a counted number of cycles before any client requests. Fallback to a higher-indexed slot owner needs a rewritten table. The stimulus therefore rewrites all 64 entries of one region to a single client, then lets a lower-indexed client compete with it. Seeded random traffic with region switches and configuration writes in flight is then checked cycle by cycle against a bench model of the schedule.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
  typedef enum logic {
    CFG_SLOT  = 1'b0,
    CFG_BURST = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int N_CLIENTS = 15,
  parameter int N_SLOTS   = 64,
  parameter int CLIENT_W  = 4,
  parameter int SLOT_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SLOT_W-1:0]   waddr_i,
  input  logic [CLIENT_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0]   raddr_i,
  output logic [CLIENT_W-1:0] rdata_o
);
  logic [CLIENT_W-1:0] mem_q [N_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOTS; i++) mem_q[i] <= CLIENT_W'(i % N_CLIENTS);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tdm_burst_cfg.sv
module tdm_burst_cfg #(
  parameter int N_CLIENTS = 15,
  parameter int BURST_W   = 4,
  parameter int BURST_RST = 3,
  parameter int IDX_W     = 6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [IDX_W-1:0]                    idx_i,
  input  logic [BURST_W-1:0]                  data_i,
  output logic [N_CLIENTS-1:0][BURST_W-1:0]   lim_o
);
  for (genvar c = 0; c < N_CLIENTS; c++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             lim_o[c] <= BURST_W'(BURST_RST);
      else if (we_i && idx_i == IDX_W'(c))     lim_o[c] <= data_i;
    end
  end
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane #(
  parameter int N_CLIENTS = 15,
  parameter int N_SLOTS   = 64,
  parameter int CLIENT_W  = 4,
  parameter int SLOT_W    = 6,
  parameter int BURST_W   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_CLIENTS-1:0]              req_i,
  input  logic [CLIENT_W-1:0]               entry_i,
  input  logic [N_CLIENTS-1:0][BURST_W-1:0] lim_i,
  output logic [SLOT_W-1:0]                 ptr_o,
  output logic [N_CLIENTS-1:0]              gnt_o
);
  logic                busy_q;
  logic [CLIENT_W-1:0] own_q;
  logic [BURST_W-1:0]  cnt_q;
  logic [SLOT_W-1:0]   ptr_q, ptr_nxt;
  logic [N_CLIENTS-1:0] ent_oh, own_oh;
  logic [CLIENT_W-1:0] low, win;
  logic [BURST_W-1:0]  lim_sel;
  logic                owner_hit, own_req;

  always_comb begin
    low     = '0;
    lim_sel = '0;
    for (int c = N_CLIENTS - 1; c >= 0; c--) begin
      ent_oh[c] = (entry_i == CLIENT_W'(c));
      own_oh[c] = (own_q == CLIENT_W'(c));
      if (req_i[c]) low = CLIENT_W'(c);
      if (own_oh[c]) lim_sel = lim_i[c];
    end
  end

  assign owner_hit = |(ent_oh & req_i);
  assign own_req   = |(own_oh & req_i);
  assign win       = owner_hit ? entry_i : low;
  assign ptr_nxt   = (ptr_q == SLOT_W'(N_SLOTS - 1)) ? '0 : ptr_q + SLOT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (!busy_q) begin
      if (|req_i) begin
        busy_q <= 1'b1;
        own_q  <= win;
        cnt_q  <= '0;
      end else begin
        ptr_q  <= ptr_nxt;
      end
    end else if (!own_req || cnt_q == lim_sel) begin
      busy_q <= 1'b0;
      ptr_q  <= ptr_nxt;
    end else begin
      cnt_q  <= cnt_q + BURST_W'(1);
    end
  end

  assign ptr_o = ptr_q;
  assign gnt_o = busy_q ? own_oh : '0;
endmodule

// File: rtl/tdm_slot_arb.sv
module tdm_slot_arb
  import tdm_arb_pkg::*;
#(
  parameter int N_CLIENTS = 15,
  parameter int N_SLOTS   = 64,
  parameter int N_REGIONS = 2,
  parameter int BURST_W   = 4,
  parameter int BURST_RST = 3,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int CLIENT_W = $clog2(N_CLIENTS + 1),
  localparam int RGN_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
  localparam int DATA_W   = (CLIENT_W > BURST_W) ? CLIENT_W : BURST_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CLIENTS-1:0]         req_i,
  input  logic [N_CLIENTS*RGN_W-1:0]   req_rgn_i,
  output logic [N_CLIENTS-1:0]         gnt_o,
  input  logic                         cfg_we_i,
  input  logic                         cfg_kind_i,
  input  logic [RGN_W-1:0]             cfg_rgn_i,
  input  logic [SLOT_W-1:0]            cfg_idx_i,
  input  logic [DATA_W-1:0]            cfg_data_i
);
  cfg_kind_e kind;
  logic [N_CLIENTS-1:0][BURST_W-1:0] lim;
  logic [N_REGIONS-1:0][N_CLIENTS-1:0] lane_req, lane_gnt;

  assign kind = cfg_kind_e'(cfg_kind_i);

  tdm_burst_cfg #(
    .N_CLIENTS(N_CLIENTS), .BURST_W(BURST_W), .BURST_RST(BURST_RST), .IDX_W(SLOT_W)
  ) i_burst_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i && kind == CFG_BURST),
    .idx_i (cfg_idx_i),
    .data_i(cfg_data_i[BURST_W-1:0]),
    .lim_o (lim)
  );

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_rgn
    logic [SLOT_W-1:0]   ptr;
    logic [CLIENT_W-1:0] entry;

    for (genvar c = 0; c < N_CLIENTS; c++) begin : g_sel
      assign lane_req[r][c] = req_i[c] && (req_rgn_i[c*RGN_W +: RGN_W] == RGN_W'(r));
    end

    tdm_slot_table #(
      .N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS), .CLIENT_W(CLIENT_W), .SLOT_W(SLOT_W)
    ) i_table (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i && kind == CFG_SLOT && cfg_rgn_i == RGN_W'(r)),
      .waddr_i(cfg_idx_i),
      .wdata_i(cfg_data_i[CLIENT_W-1:0]),
      .raddr_i(ptr),
      .rdata_o(entry)
    );

    tdm_lane #(
      .N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS), .CLIENT_W(CLIENT_W),
      .SLOT_W(SLOT_W), .BURST_W(BURST_W)
    ) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (lane_req[r]),
      .entry_i(entry),
      .lim_i  (lim),
      .ptr_o  (ptr),
      .gnt_o  (lane_gnt[r])
    );
  end

  always_comb begin
    gnt_o = '0;
    for (int r = 0; r < N_REGIONS; r++) gnt_o |= lane_gnt[r];
  end
endmodule

// File: rtl/tdm_slot_arb_chk.sv
module tdm_slot_arb_chk #(
  parameter int N_CLIENTS = 15,
  parameter int N_REGIONS = 2,
  parameter int BURST_W   = 4,
  parameter int RGN_W     = 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CLIENTS-1:0]       req_i,
  input logic [N_CLIENTS*RGN_W-1:0] req_rgn_i,
  input logic [N_CLIENTS-1:0]       gnt_o
);
  localparam int RUN_W = BURST_W + 2;
  localparam logic [RUN_W-1:0] MAX_BEATS = RUN_W'(1 << BURST_W);

  p_gnt_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~$past(req_i)) == '0);

  p_lane_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) <= N_REGIONS);

  for (genvar c = 0; c < N_CLIENTS; c++) begin : g_cl
    logic [RGN_W-1:0] rgn_d1, rgn_d2;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rgn_d1 <= '0;
        rgn_d2 <= '0;
        run_q  <= '0;
      end else begin
        rgn_d1 <= req_rgn_i[c*RGN_W +: RGN_W];
        rgn_d2 <= rgn_d1;
        if (!gnt_o[c])               run_q <= '0;
        else if (rgn_d1 != rgn_d2)   run_q <= RUN_W'(1);
        else if (run_q != '1)        run_q <= run_q + RUN_W'(1);
      end
    end

    p_drop_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[c] && !req_i[c]) |=> !gnt_o[c]);

    p_burst_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= MAX_BEATS);
  end
endmodule

bind tdm_slot_arb tdm_slot_arb_chk #(
  .N_CLIENTS(N_CLIENTS), .N_REGIONS(N_REGIONS), .BURST_W(BURST_W), .RGN_W(RGN_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .req_rgn_i(req_rgn_i),
  .gnt_o    (gnt_o)
);

// File: tb/test_tdm_slot_arb.sv
`timescale 1ns/1ps
module test_tdm_slot_arb;
  localparam int N = 15;
  localparam int S = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [N-1:0]  req_rgn_i = '0;
  logic [N-1:0]  gnt_o;
  logic          cfg_we_i = 1'b0;
  logic          cfg_kind_i = 1'b0;
  logic          cfg_rgn_i = 1'b0;
  logic [5:0]    cfg_idx_i = '0;
  logic [3:0]    cfg_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [3:0] m_tab [2][S];
  logic [3:0] m_lim [N];
  int m_ptr [2];
  bit m_busy [2];
  int m_own [2];
  int m_cnt [2];

  always #5 clk_i = ~clk_i;

  tdm_slot_arb i_tdm_slot_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_rgn_i(req_rgn_i),
    .gnt_o(gnt_o), .cfg_we_i(cfg_we_i), .cfg_kind_i(cfg_kind_i),
    .cfg_rgn_i(cfg_rgn_i), .cfg_idx_i(cfg_idx_i), .cfg_data_i(cfg_data_i)
  );

  task automatic check_eq(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s gnt_o=%h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_gnt();
    logic [N-1:0] g = '0;
    for (int r = 0; r < 2; r++) if (m_busy[r]) g[m_own[r]] = 1'b1;
    return g;
  endfunction

  task automatic m_reset();
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < S; i++) m_tab[r][i] = 4'(i % N);
      m_ptr[r] = 0; m_busy[r] = 0; m_own[r] = 0; m_cnt[r] = 0;
    end
    for (int c = 0; c < N; c++) m_lim[c] = 4'd3;
  endtask

  task automatic m_next(logic [N-1:0] rq, logic [N-1:0] rg, bit we, bit kind,
                        bit rgn, int idx, int data);
    for (int r = 0; r < 2; r++) begin
      logic [N-1:0] rv = rq & (r == 1 ? rg : ~rg);
      if (!m_busy[r]) begin
        if (rv != '0) begin
          int e = m_tab[r][m_ptr[r]];
          int w = 0;
          for (int c = N - 1; c >= 0; c--) if (rv[c]) w = c;
          if (e < N && rv[e]) w = e;
          m_busy[r] = 1; m_own[r] = w; m_cnt[r] = 0;
        end else m_ptr[r] = (m_ptr[r] + 1) % S;
      end else if (!rv[m_own[r]] || m_cnt[r] == m_lim[m_own[r]]) begin
        m_busy[r] = 0; m_ptr[r] = (m_ptr[r] + 1) % S;
      end else m_cnt[r]++;
    end
    if (we) begin
      if (!kind) m_tab[rgn][idx] = 4'(data);
      else if (idx < N) m_lim[idx] = 4'(data);
    end
  endtask

  task automatic step(string tag, logic [N-1:0] rq, logic [N-1:0] rg,
                      bit we = 0, bit kind = 0, bit rgn = 0, int idx = 0, int data = 0);
    req_i = rq; req_rgn_i = rg; cfg_we_i = we; cfg_kind_i = kind;
    cfg_rgn_i = rgn; cfg_idx_i = 6'(idx); cfg_data_i = 4'(data);
    m_next(rq, rg, we, kind, rgn, idx, data);
    @(negedge clk_i);
    check_eq(tag, gnt_o, m_gnt());
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_i = '0; req_rgn_i = '0; cfg_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    m_reset();
    rst_ni = 1'b1;
    check_eq("R1 reset", gnt_o, '0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rq, rg;
    void'($urandom(32'h5EED_1234));

    // R1/R2/R6: default table and default 4-beat burst
    do_reset();
    step("R2", '1, '0); check_eq("R1 slot0 owner", gnt_o, 15'h0001);
    for (int i = 0; i < 3; i++) begin
      step("R1", '1, '0); check_eq("R1 four beats", gnt_o, 15'h0001);
    end
    step("R4", '1, '0); check_eq("R4 gap", gnt_o, '0);
    step("R6", '1, '0); check_eq("R6 next slot", gnt_o, 15'h0002);

    // R3/R10: fallback to lowest and early release
    do_reset();
    step("R3", 15'h0240, 15'h0240); check_eq("R3 lowest", gnt_o, 15'h0040);
    step("R10", 15'h0200, 15'h0200); check_eq("R10 drop", gnt_o, '0);
    step("R3", 15'h0200, 15'h0200); check_eq("R3 fallback", gnt_o, 15'h0200);

    // R8: single-beat limit, out-of-range index ignored
    do_reset();
    step("R8", '0, '0, 1, 1, 0, 2, 0);
    step("R8", '0, '0, 1, 1, 0, 17, 0);
    step("R8", 15'h0006, '0); check_eq("R8 one beat", gnt_o, 15'h0004);
    step("R8", 15'h0006, '0); check_eq("R8 gap", gnt_o, '0);
    for (int i = 0; i < 4; i++) begin
      step("R8", 15'h0006, '0); check_eq("R8 idx17 ignored", gnt_o, 15'h0002);
    end
    step("R8", 15'h0006, '0); check_eq("R8 end", gnt_o, '0);

    // R7: rewritten table favours a higher-index owner
    do_reset();
    for (int i = 0; i < S; i++) step("R7", '0, '0, 1, 0, 1, i, 12);
    step("R7", 15'h1008, 15'h1008); check_eq("R7 owner 12", gnt_o, 15'h1000);

    // R5: wrap from slot 63 to slot 0
    do_reset();
    for (int i = 0; i < S - 1; i++) step("R5", '0, '0);
    step("R5", 15'h0009, '0); check_eq("R5 slot63 owner", gnt_o, 15'h0008);
    for (int i = 0; i < 4; i++) step("R5", 15'h0009, '0);
    step("R5", 15'h0009, '0); check_eq("R5 wrapped", gnt_o, 15'h0001);

    // R9: lanes work side by side
    do_reset();
    step("R9", 15'h0006, 15'h0004); check_eq("R9 two lanes", gnt_o, 15'h0006);

    // R4: seeded random traffic against the model
    do_reset();
    rq = '0; rg = '0;
    for (int t = 0; t < 4000; t++) begin
      bit we = ($urandom % 16) == 0;
      for (int c = 0; c < N; c++) begin
        if ($urandom % 4 == 0) rq[c] = ~rq[c];
        if ($urandom % 16 == 0) rg[c] = ~rg[c];
      end
      step("R4 random", rq, rg, we, 1'($urandom), 1'($urandom),
           int'($urandom % S), int'($urandom % 16));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule